// File: doc/BRIEF.md
# AXI Read-Channel Performance Monitor

This block watches one AXI read channel without driving it and gathers raw statistics for bandwidth and latency. Six saturating counters run only while a measurement window is open: elapsed window cycles, cycles with read data valid, cycles with a read-data handshake, completed bursts, cycles with a read address pending, and a latency accumulator. Software forms averages from these raw counts, for example accumulated latency divided by completed bursts.

A tracker keeps the number of read bursts that have been accepted on the address channel but have not yet returned their last data beat. It runs from reset whether or not a window is open, so the count is correct when a window opens in the middle of traffic. While a window is open, the latency accumulator adds the tracker's value on every cycle. Software can switch the tracker off when latency is not needed. A window is opened and closed by command, or it closes itself after a programmed number of cycles.

Control and readback use a simple word-addressed register port. Writes take effect on the clock edge where `reg_valid` and `reg_write` are high. Read data is a combinational function of `reg_addr`. Addresses: 0 control, 1 limit, 2 status, 3 window cycles, 4 data-valid cycles, 5 data handshakes, 6 bursts, 7 address-pending cycles, 8 latency. Counter values are zero-extended to 32 bits.

Top module: `axi_rd_perfmon`

## Requirements
- R1: After reset, every counter, the limit, the status word and the control readback read as zero.
- R2: A control write (address 0) with bit 0 set opens the window from the next cycle, and one with bit 1 set closes it (bit 0 wins if both are set). The window-cycle counter (address 3) adds one for every clock edge at which the window is open. Status bit 0 shows the window open.
- R3: While the window is open, address 4 counts cycles with `mon_rvalid` high, and address 5 counts cycles with both `mon_rvalid` and `mon_rready` high.
- R4: While the window is open, address 6 counts handshaked data beats that have `mon_rlast` high, and address 7 counts cycles with `mon_arvalid` high.
- R5: The outstanding-burst count, read in status bits [15:8], rises by one on each address handshake and falls by one on each handshaked last beat. Both together leave it unchanged. It holds at zero and at its maximum value. It runs from reset whether or not the window is open.
- R6: While the window is open and tracking is enabled, address 8 adds the outstanding-burst count present at each clock edge.
- R7: Every control write loads control bit 4 (tracking off) and bit 3 (timer mode). Both read back at the same positions. While tracking is off, the outstanding count is held at zero and latency does not accumulate.
- R8: In timer mode the window closes by itself at the edge where the window-cycle count reaches max(limit, 1), where the limit is the 32-bit value at address 1. Status bit 1 (done) is then set. It is cleared by an open command or a clear command.
- R9: Every counter saturates at its all-ones value. Any increment that would carry past it sets status bit 2, which stays set until a clear command.
- R10: A control write with bit 2 set zeroes all six counters and the done and overflow flags. It leaves the outstanding count unchanged.
- R11: While the window is closed, no counter changes, whatever happens on the monitored channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | Access is a write when high |
| reg_addr | input | ADDR_W | Word address of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| mon_arvalid | input | 1 | Observed read-address valid |
| mon_arready | input | 1 | Observed read-address ready |
| mon_rvalid | input | 1 | Observed read-data valid |
| mon_rready | input | 1 | Observed read-data ready |
| mon_rlast | input | 1 | Observed last-beat marker |

## Verification
The assertions assume the monitored channel is well formed: no last beat arrives with nothing outstanding, and the outstanding count stays below the tracker's saturation point. The increment checks only apply away from the limits. The random stimulus keeps within this by making address handshakes about as likely as last beats. Bursts stay short relative to the 8-bit tracker, and one directed case drives a last beat with nothing outstanding to check the floor.

The bench shortens the counters to 12 bits so that saturation and the overflow flag can be reached within the run.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  // counter slots, in readback order
  localparam int NUM_CNT   = 6;
  localparam int IX_GLOBAL = 0;
  localparam int IX_BUSY   = 1;
  localparam int IX_DATA   = 2;
  localparam int IX_XFER   = 3;
  localparam int IX_ABUSY  = 4;
  localparam int IX_LAT    = 5;

  // word addresses
  localparam int A_CTRL    = 0;
  localparam int A_LIMIT   = 1;
  localparam int A_STATUS  = 2;
  localparam int A_CNT0    = 3;

  // control word bits
  localparam int C_START   = 0;
  localparam int C_STOP    = 1;
  localparam int C_CLEAR   = 2;
  localparam int C_TIMER   = 3;
  localparam int C_TRKOFF  = 4;

  // status word bits
  localparam int S_ACTIVE  = 0;
  localparam int S_DONE    = 1;
  localparam int S_OVF     = 2;
  localparam int S_OT_LSB  = 8;
  localparam int S_OT_MAXW = 8;
endpackage

// File: rtl/perfmon_acc.sv
module perfmon_acc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         en,
  input  logic [W-1:0] add,
  output logic [W-1:0] value,
  output logic         ovf_evt
);
  logic [W-1:0] acc_q;
  logic [W:0]   wide_sum;

  function automatic logic [W:0] widen_add(logic [W-1:0] a, logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  assign wide_sum = widen_add(acc_q, add);
  assign ovf_evt  = en & wide_sum[W];
  assign value    = acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      acc_q <= '0;
    else if (clear)  acc_q <= '0;
    else if (en)     acc_q <= wide_sum[W] ? '1 : wide_sum[W-1:0];
  end
endmodule

// File: rtl/perfmon_track.sv
module perfmon_track #(
  parameter int OT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold_zero,
  input  logic            ar_hs,
  input  logic            r_end,
  output logic [OT_W-1:0] count
);
  logic [OT_W-1:0] cnt_q;

  function automatic logic [OT_W-1:0] step(logic [OT_W-1:0] c, logic up, logic dn);
    logic [OT_W-1:0] r;
    r = c;
    if (up && !dn && c != '1) r = c + 1'b1;
    if (dn && !up && c != '0) r = c - 1'b1;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (hold_zero) cnt_q <= '0;
    else                cnt_q <= step(cnt_q, ar_hs, r_end);
  end

  assign count = cnt_q;
endmodule

// File: rtl/perfmon_ctrl.sv
module perfmon_ctrl
  import perfmon_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_limit,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  global_cnt,
  output logic              active,
  output logic              done,
  output logic              timer_mode,
  output logic              trk_off,
  output logic              start_pulse,
  output logic              clear_pulse,
  output logic              timer_end,
  output logic [DATA_W-1:0] limit
);
  localparam int CMP_W = ((CNT_W > DATA_W) ? CNT_W : DATA_W) + 1;

  logic stop_pulse;
  logic active_q, done_q, tmode_q, trk_q;
  logic [DATA_W-1:0] limit_q;

  function automatic logic limit_reached(logic [CNT_W-1:0] cnt, logic [DATA_W-1:0] lim);
    logic [CMP_W-1:0] nxt;
    nxt = CMP_W'(cnt) + CMP_W'(1);
    return nxt >= CMP_W'(lim);
  endfunction

  assign start_pulse = wr_ctrl & wdata[C_START];
  assign stop_pulse  = wr_ctrl & wdata[C_STOP];
  assign clear_pulse = wr_ctrl & wdata[C_CLEAR];
  assign timer_end   = active_q & tmode_q & limit_reached(global_cnt, limit_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      tmode_q  <= 1'b0;
      trk_q    <= 1'b0;
      limit_q  <= '0;
    end else begin
      if (start_pulse)     active_q <= 1'b1;
      else if (stop_pulse) active_q <= 1'b0;
      else if (timer_end)  active_q <= 1'b0;

      if (start_pulse || clear_pulse) done_q <= 1'b0;
      else if (timer_end)             done_q <= 1'b1;

      if (wr_ctrl) begin
        tmode_q <= wdata[C_TIMER];
        trk_q   <= wdata[C_TRKOFF];
      end
      if (wr_limit) limit_q <= wdata;
    end
  end

  assign active     = active_q;
  assign done       = done_q;
  assign timer_mode = tmode_q;
  assign trk_off    = trk_q;
  assign limit      = limit_q;
endmodule

// File: rtl/axi_rd_perfmon.sv
module axi_rd_perfmon
  import perfmon_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int OT_W   = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              mon_arvalid,
  input  logic              mon_arready,
  input  logic              mon_rvalid,
  input  logic              mon_rready,
  input  logic              mon_rlast
);
  // named internal events
  logic wr_any, wr_ctrl, wr_limit;
  logic ar_hs, r_hs, r_end;
  logic active, done, timer_mode, trk_off;
  logic start_pulse, clear_pulse, timer_end;
  logic ovf_q;
  logic [DATA_W-1:0] limit;
  logic [OT_W-1:0]   ot_count;
  logic [CNT_W-1:0]  cnt_val [NUM_CNT];
  logic [CNT_W-1:0]  add_v   [NUM_CNT];
  logic [NUM_CNT-1:0] en_v, ovf_v;
  logic [CNT_W-1:0]  glob_cnt;

  assign wr_any   = reg_valid & reg_write;
  assign wr_ctrl  = wr_any & (reg_addr == ADDR_W'(A_CTRL));
  assign wr_limit = wr_any & (reg_addr == ADDR_W'(A_LIMIT));

  assign ar_hs = mon_arvalid & mon_arready;
  assign r_hs  = mon_rvalid & mon_rready;
  assign r_end = r_hs & mon_rlast;

  perfmon_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ctrl     (wr_ctrl),
    .wr_limit    (wr_limit),
    .wdata       (reg_wdata),
    .global_cnt  (glob_cnt),
    .active      (active),
    .done        (done),
    .timer_mode  (timer_mode),
    .trk_off     (trk_off),
    .start_pulse (start_pulse),
    .clear_pulse (clear_pulse),
    .timer_end   (timer_end),
    .limit       (limit)
  );

  perfmon_track #(.OT_W(OT_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_zero (trk_off),
    .ar_hs     (ar_hs),
    .r_end     (r_end),
    .count     (ot_count)
  );

  always_comb begin
    add_v[IX_GLOBAL] = CNT_W'(1);
    add_v[IX_BUSY]   = CNT_W'(mon_rvalid);
    add_v[IX_DATA]   = CNT_W'(r_hs);
    add_v[IX_XFER]   = CNT_W'(r_end);
    add_v[IX_ABUSY]  = CNT_W'(mon_arvalid);
    add_v[IX_LAT]    = CNT_W'(ot_count);
    for (int i = 0; i < NUM_CNT; i++) en_v[i] = active;
    en_v[IX_LAT] = active & ~trk_off;
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    perfmon_acc #(.W(CNT_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clear_pulse),
      .en      (en_v[g]),
      .add     (add_v[g]),
      .value   (cnt_val[g]),
      .ovf_evt (ovf_v[g])
    );
  end

  assign glob_cnt = cnt_val[IX_GLOBAL];

  always_ff @(posedge clk) begin
    if (!rst_n)          ovf_q <= 1'b0;
    else if (clear_pulse) ovf_q <= 1'b0;
    else if (|ovf_v)      ovf_q <= 1'b1;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(A_CTRL)) begin
      reg_rdata[C_TIMER]  = timer_mode;
      reg_rdata[C_TRKOFF] = trk_off;
    end else if (reg_addr == ADDR_W'(A_LIMIT)) begin
      reg_rdata = limit;
    end else if (reg_addr == ADDR_W'(A_STATUS)) begin
      reg_rdata[S_ACTIVE] = active;
      reg_rdata[S_DONE]   = done;
      reg_rdata[S_OVF]    = ovf_q;
      reg_rdata[S_OT_LSB +: OT_W] = ot_count;
    end else begin
      for (int i = 0; i < NUM_CNT; i++)
        if (reg_addr == ADDR_W'(A_CNT0 + i)) reg_rdata[CNT_W-1:0] = cnt_val[i];
    end
  end
endmodule

// File: rtl/perfmon_chk.sv
module perfmon_chk #(
  parameter int CNT_W = 32,
  parameter int OT_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             active,
  input logic             done,
  input logic             ovf,
  input logic             start_pulse,
  input logic             clear_pulse,
  input logic             timer_end,
  input logic             trk_off,
  input logic             ar_hs,
  input logic             r_end,
  input logic [OT_W-1:0]  ot_count,
  input logic [CNT_W-1:0] glob
);
  // R2
  global_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !clear_pulse && glob != '1) |=> glob == CNT_W'($past(glob) + 1'b1));

  // R11
  frozen_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !clear_pulse) |=> $stable(glob));

  // R5
  ot_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trk_off && ar_hs && !r_end && ot_count != '1) |=> ot_count == OT_W'($past(ot_count) + 1'b1));

  // R7
  trk_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trk_off |=> ot_count == '0);

  // R8
  timer_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_end && !start_pulse && !clear_pulse) |=> (!active && done));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clear_pulse) |=> ovf);

  // R10
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_pulse |=> (glob == '0 && !ovf && !done));
endmodule

bind axi_rd_perfmon perfmon_chk #(.CNT_W(CNT_W), .OT_W(OT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .active      (active),
  .done        (done),
  .ovf         (ovf_q),
  .start_pulse (start_pulse),
  .clear_pulse (clear_pulse),
  .timer_end   (timer_end),
  .trk_off     (trk_off),
  .ar_hs       (ar_hs),
  .r_end       (r_end),
  .ot_count    (ot_count),
  .glob        (glob_cnt)
);

// File: tb/axi_rd_perfmon_test.sv
module axi_rd_perfmon_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 12;
  localparam int OT_W   = 8;
  localparam int ADDR_W = 4;
  localparam longint MAXC = (64'd1 << CNT_W) - 1;
  localparam longint MAXO = (64'd1 << OT_W) - 1;

  logic clk, rst_n;
  logic reg_valid, reg_write;
  logic [ADDR_W-1:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic mon_arvalid, mon_arready, mon_rvalid, mon_rready, mon_rlast;

  axi_rd_perfmon #(.CNT_W(CNT_W), .OT_W(OT_W), .ADDR_W(ADDR_W), .DATA_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mon_arvalid(mon_arvalid), .mon_arready(mon_arready), .mon_rvalid(mon_rvalid),
    .mon_rready(mon_rready), .mon_rlast(mon_rlast));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // ---------------- reference model, written from the requirements
  longint m_cnt [6];
  longint m_lim, m_ot;
  bit m_active, m_done, m_ovf, m_tmode, m_trk;

  function automatic longint model_next_ot(longint ot, bit up, bit dn);
    if (up && !dn && ot < MAXO) return ot + 1;
    if (dn && !up && ot > 0) return ot - 1;
    return ot;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_cnt[i]) m_cnt[i] = 0;
      m_lim = 0; m_ot = 0;
      m_active = 0; m_done = 0; m_ovf = 0; m_tmode = 0; m_trk = 0;
    end else begin
      bit wc, wl, st, sp, cl, tend, up, dn;
      longint ev [6];
      longint s;
      wc = reg_valid && reg_write && reg_addr == 0;
      wl = reg_valid && reg_write && reg_addr == 1;
      st = wc && reg_wdata[0];
      sp = wc && reg_wdata[1];
      cl = wc && reg_wdata[2];
      up = mon_arvalid && mon_arready;
      dn = mon_rvalid && mon_rready && mon_rlast;
      ev[0] = 1;
      ev[1] = mon_rvalid;
      ev[2] = mon_rvalid && mon_rready;
      ev[3] = dn;
      ev[4] = mon_arvalid;
      ev[5] = m_trk ? 0 : m_ot;
      tend = m_active && m_tmode && (m_cnt[0] + 1 >= m_lim);
      if (cl) begin
        foreach (m_cnt[i]) m_cnt[i] = 0;
        m_ovf = 0;
      end else if (m_active) begin
        for (int i = 0; i < 6; i++) begin
          s = m_cnt[i] + ev[i];
          if (s > MAXC) begin m_cnt[i] = MAXC; m_ovf = 1; end
          else m_cnt[i] = s;
        end
      end
      if (st || cl) m_done = 0; else if (tend) m_done = 1;
      if (st) m_active = 1; else if (sp) m_active = 0; else if (tend) m_active = 0;
      m_ot = m_trk ? 0 : model_next_ot(m_ot, up, dn);
      if (wc) begin m_tmode = reg_wdata[3]; m_trk = reg_wdata[4]; end
      if (wl) m_lim = reg_wdata;
    end
  end

  function automatic longint model_status();
    return (m_ot << 8) | (longint'(m_ovf) << 2) | (longint'(m_done) << 1) | longint'(m_active);
  endfunction

  function automatic logic [31:0] ctl(bit st, bit sp, bit cl, bit tm, bit trk);
    return {27'd0, trk, tm, cl, sp, st};
  endfunction

  // ---------------- helpers
  task automatic check(string req, string what, longint got, longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(negedge clk);
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic rd(int a, output longint d);
    @(negedge clk);
    reg_addr = ADDR_W'(a);
    #1 d = longint'(reg_rdata);
  endtask

  task automatic bus_idle();
    mon_arvalid = 0; mon_arready = 0; mon_rvalid = 0; mon_rready = 0; mon_rlast = 0;
  endtask

  task automatic traffic(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      mon_arvalid = ($urandom % 4) == 0;
      mon_arready = $urandom % 2;
      mon_rvalid  = $urandom % 2;
      mon_rready  = $urandom % 2;
      mon_rlast   = ($urandom % 2) == 0;
    end
    @(negedge clk);
    bus_idle();
  endtask

  task automatic check_all(string tag);
    longint v;
    string names [6] = '{"window cycles R2", "valid cycles R3", "handshakes R3",
                         "bursts R4", "addr pending R4", "latency R6"};
    for (int i = 0; i < 6; i++) begin
      rd(3 + i, v);
      check(tag, names[i], v, m_cnt[i]);
    end
    rd(2, v);
    check(tag, "status", v, model_status());
  endtask

  // ---------------- watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- main sequence
  initial begin
    longint v, saved [6];
    void'($urandom(32'd4711));
    rst_n = 0; reg_valid = 0; reg_write = 0; reg_addr = 0; reg_wdata = 0;
    bus_idle();
    repeat (5) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int i = 0; i < 9; i++) begin
      rd(i, v);
      check("R1", $sformatf("reg %0d after reset", i), v, 0);
    end

    // R5 tracker runs with window closed; R11 counters stay frozen
    @(negedge clk); mon_arvalid = 1; mon_arready = 1;
    repeat (3) @(negedge clk);
    bus_idle();
    rd(2, v);
    check("R5", "outstanding before window", v, 3 << 8);
    rd(7, v);
    check("R11", "addr pending with window closed", v, 0);

    // R2 R3 R4 R6 manual window with random traffic
    wr(0, ctl(1, 0, 0, 0, 0));
    traffic(200);
    wr(0, ctl(0, 1, 0, 0, 0));
    check_all("R2");
    rd(2, v);
    check("R2", "window closed flag", v & 1, 0);
    for (int i = 0; i < 6; i++) begin rd(3 + i, v); saved[i] = v; end

    // R11 no counting after close
    traffic(50);
    for (int i = 0; i < 6; i++) begin
      rd(3 + i, v);
      check("R11", $sformatf("counter %0d frozen", i), v, saved[i]);
    end

    // R10 clear keeps outstanding count
    wr(0, ctl(0, 0, 1, 0, 0));
    for (int i = 0; i < 6; i++) begin
      rd(3 + i, v);
      check("R10", $sformatf("counter %0d cleared", i), v, 0);
    end
    rd(2, v);
    check("R10", "status after clear", v, model_status());

    // R7 tracking off
    wr(0, ctl(1, 0, 0, 0, 1));
    rd(0, v);
    check("R7", "control readback", v, 32'h10);
    traffic(100);
    wr(0, ctl(0, 1, 0, 0, 1));
    rd(2, v);
    check("R7", "outstanding held at zero", v >> 8, 0);
    rd(8, v);
    check("R7", "latency with tracking off", v, 0);
    wr(0, ctl(0, 0, 1, 0, 0));

    // R5 floor: last beat with nothing outstanding
    @(negedge clk); mon_rvalid = 1; mon_rready = 1; mon_rlast = 1;
    @(negedge clk); bus_idle();
    rd(2, v);
    check("R5", "outstanding floor", v >> 8, 0);

    // R8 timer window, limit 37
    wr(1, 37);
    wr(0, ctl(0, 0, 1, 1, 0));
    wr(0, ctl(1, 0, 0, 1, 0));
    repeat (60) @(negedge clk);
    rd(3, v);
    check("R8", "window cycles at limit 37", v, 37);
    rd(2, v);
    check("R8", "done set, window closed", v & 3, 2);
    // R8 limit zero gives one cycle
    wr(1, 0);
    wr(0, ctl(0, 0, 1, 1, 0));
    rd(2, v);
    check("R8", "done cleared by clear", v & 2, 0);
    wr(0, ctl(1, 0, 0, 1, 0));
    repeat (10) @(negedge clk);
    rd(3, v);
    check("R8", "window cycles at limit 0", v, 1);
    // R8 timer window with traffic
    wr(1, 123);
    wr(0, ctl(0, 0, 1, 1, 0));
    wr(0, ctl(1, 0, 0, 1, 0));
    traffic(180);
    check_all("R8");

    // R9 saturation and sticky overflow
    wr(0, ctl(0, 0, 1, 0, 0));
    wr(0, ctl(1, 0, 0, 0, 0));
    repeat (4200) @(negedge clk);
    rd(3, v);
    check("R9", "window cycles saturated", v, MAXC);
    rd(2, v);
    check("R9", "overflow flag", (v >> 2) & 1, 1);
    wr(0, ctl(0, 1, 0, 0, 0));
    rd(2, v);
    check("R9", "overflow still set", (v >> 2) & 1, 1);
    wr(0, ctl(0, 0, 1, 0, 0));
    rd(2, v);
    check("R10", "overflow cleared", (v >> 2) & 1, 0);

    // random manual windows against the model
    for (int it = 0; it < 6; it++) begin
      wr(0, ctl(0, 0, 1, 0, 0));
      wr(0, ctl(1, 0, 0, 0, 0));
      traffic(100 + ($urandom % 300));
      wr(0, ctl(0, 1, 0, 0, 0));
      check_all("R6");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule